// File: doc/BRIEF.md
# Descending Stack Unit

This block keeps a last-in first-out store of data words in a small word-addressed RAM. A stack pointer register tracks where the next word will be stored. The stack starts at a high address and grows toward lower addresses. A push stores the incoming word at the address held in the pointer and then moves the pointer down by one. A pop first moves the pointer up by one and then reads the word at that new address. In this convention the pointer always marks the next free slot. When the pointer is at the start address, the stack is empty.

The stack's capacity is set by two parameters. One is the start (empty) address. The other is a floor address below which the stack may not grow. The floor slot itself is never written, so the capacity is the start address minus the floor address. The block rejects three kinds of operation: a push when the pointer sits at the floor, a pop when the stack is empty, and a push and a pop in the same cycle. Each of these sets its own sticky error flag and changes neither the pointer nor the memory. The flags clear only on reset. Popped data comes from a registered RAM read and is marked by a valid pulse one cycle long.

Top module: `dstack_unit`

## Requirements
- R1: After reset, the pointer equals the start address, all three error flags are 0 and the read-valid output is 0.
- R2: A push (push strobe 1, pop strobe 0) with the pointer above the floor writes the data word at the pointer's address. The pointer is one lower in the next cycle.
- R3: A pop (pop strobe 1, push strobe 0) with the pointer below the start address makes the pointer one higher in the next cycle. In that same next cycle, the read data holds the word at the new pointer address and read-valid is 1 for exactly one cycle.
- R4: Words come back from pops in the reverse of the order in which they were pushed, including after pushes and pops are interleaved.
- R5: A push while the pointer equals the floor address sets the overflow flag. The pointer does not change, and the memory does not change, so later pops return only the earlier words.
- R6: A pop while the pointer equals the start address sets the underflow flag. The pointer does not change and read-valid stays 0.
- R7: A push and a pop in the same cycle set the collision flag. Neither operation happens: the pointer and memory do not change and read-valid stays 0.
- R8: Each error flag, once set, stays at 1 until reset. Valid operations that follow it still execute normally.
- R9: The pointer never leaves the range from the floor address to the start address, inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| wdata_i | input | DATA_W | Word to push |
| rdata_o | output | DATA_W | Popped word, meaningful while rvalid_o is 1 |
| rvalid_o | output | 1 | One-cycle pulse marking popped data |
| sp_o | output | ADDR_W | Current stack pointer |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| clash_o | output | 1 | Sticky push-and-pop collision flag |

## Verification
Two events can fall in the same cycle: a push strobe and a pop strobe, and an operation together with a boundary condition. The bench raises both strobes together while the stack is partly full. It expects the collision flag to rise, the pointer to hold, and no valid pulse. A later pop must then return the word pushed before the collision, which shows that memory was left untouched. Pushes at the floor and pops at the start address are also driven. Each must set its own flag and leave the pointer and the stacked words exactly as they were.

// File: rtl/dstack_pkg.sv
package dstack_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLASH = 2'd3
  } op_e;

  function automatic op_e decode_op(input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return OP_PUSH;
      2'b01:   return OP_POP;
      2'b11:   return OP_CLASH;
      default: return OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dstack_ptr.sv
module dstack_ptr
  import dstack_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int BASE_ADDR  = 15,
  parameter int FLOOR_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] sp_q,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              ovf_q,
  output logic              unf_q,
  output logic              clash_q
);

  localparam logic [ADDR_W-1:0] BASE_SP  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] FLOOR_SP = ADDR_W'(FLOOR_ADDR);
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

  op_e  op;
  logic at_floor;
  logic at_base;
  logic ovf_evt;
  logic unf_evt;

  always_comb begin
    op       = decode_op(push, pop);
    at_floor = (sp_q == FLOOR_SP);
    at_base  = (sp_q == BASE_SP);
    wr_en    = (op == OP_PUSH) && !at_floor;
    rd_en    = (op == OP_POP) && !at_base;
    ovf_evt  = (op == OP_PUSH) && at_floor;
    unf_evt  = (op == OP_POP) && at_base;
    wr_addr  = sp_q;
    rd_addr  = sp_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= BASE_SP;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      clash_q <= 1'b0;
    end else begin
      if (wr_en) begin
        sp_q <= sp_q - ONE;
      end else if (rd_en) begin
        sp_q <= sp_q + ONE;
      end
      if (ovf_evt)          ovf_q   <= 1'b1;
      if (unf_evt)          unf_q   <= 1'b1;
      if (op == OP_CLASH)   clash_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dstack_mem.sv
module dstack_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
    end
  end

endmodule

// File: rtl/dstack_unit.sv
module dstack_unit #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int BASE_ADDR  = 15,
  parameter int FLOOR_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              clash_o
);

  logic              wr_en;
  logic              rd_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;

  dstack_ptr #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .FLOOR_ADDR(FLOOR_ADDR)
  ) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .push   (push_i),
    .pop    (pop_i),
    .sp_q   (sp_o),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .ovf_q  (ovf_o),
    .unf_q  (unf_o),
    .clash_q(clash_o)
  );

  dstack_mem #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wdata_i),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rdata_o),
    .rvalid(rvalid_o)
  );

endmodule

// File: rtl/dstack_checker.sv
module dstack_checker #(
  parameter int ADDR_W     = 4,
  parameter int BASE_ADDR  = 15,
  parameter int FLOOR_ADDR = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              push_i,
  input logic              pop_i,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              ovf_o,
  input logic              unf_o,
  input logic              clash_o
);

  localparam logic [ADDR_W-1:0] BASE_SP  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] FLOOR_SP = ADDR_W'(FLOOR_ADDR);
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

  a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && sp_o != FLOOR_SP) |=> (sp_o == $past(sp_o) - ONE));

  a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && sp_o != BASE_SP) |=> (rvalid_o && sp_o == $past(sp_o) + ONE));

  a_r3_valid_cause: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> $past(pop_i && !push_i));

  a_r5_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && sp_o == FLOOR_SP) |=> (ovf_o && $stable(sp_o)));

  a_r6_underflow: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && sp_o == BASE_SP) |=> (unf_o && $stable(sp_o) && !rvalid_o));

  a_r7_collision: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> (clash_o && $stable(sp_o) && !rvalid_o));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  a_r8_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    unf_o |=> unf_o);

  a_r8_clash_sticky: assert property (@(posedge clk) disable iff (rst)
    clash_o |=> clash_o);

  a_r9_range: assert property (@(posedge clk) disable iff (rst)
    (sp_o <= BASE_SP) && (sp_o >= FLOOR_SP));

endmodule

bind dstack_unit dstack_checker #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .FLOOR_ADDR(FLOOR_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .rvalid_o(rvalid_o),
  .sp_o    (sp_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o),
  .clash_o (clash_o)
);

// File: tb/tb_dstack_unit.sv
module tb_dstack_unit;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int BASE   = 15;
  localparam int FLOOR  = 8;
  localparam int CAP    = BASE - FLOOR;
  localparam int NVEC   = 10;
  localparam int VW     = 42;

  // vector: push, pop, wdata[16], exp_sp[4], exp_valid, exp_rdata[16], exp_ovf, exp_unf, exp_clash
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'hA1A1, 4'd14, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'hB2B2, 4'd13, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0000, 4'd14, 1'b1, 16'hB2B2, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'hC3C3, 4'd13, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0000, 4'd14, 1'b1, 16'hC3C3, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0000, 4'd15, 1'b1, 16'hA1A1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0000, 4'd15, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'hD4D4, 4'd14, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'hEEEE, 4'd14, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b1, 16'h0000, 4'd15, 1'b1, 16'hD4D4, 1'b0, 1'b1, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              push_i = 1'b0;
  logic              pop_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              rvalid_o;
  logic [ADDR_W-1:0] sp_o;
  logic              ovf_o;
  logic              unf_o;
  logic              clash_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  dstack_unit #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .FLOOR_ADDR(FLOOR)
  ) dut (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .sp_o(sp_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .clash_o(clash_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ps, input logic pp, input logic [DATA_W-1:0] d);
    push_i  = ps;
    pop_i   = pp;
    wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    push_i  = 1'b0;
    pop_i   = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 sp", 32'(sp_o), BASE);
    chk("R1 flags", {29'd0, ovf_o, unf_o, clash_o}, 0);
    chk("R1 rvalid", 32'(rvalid_o), 0);

    // table walk: R2 R3 R4 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[41], v[40], v[39:24]);
      chk($sformatf("R2/R3 vec%0d sp", i), 32'(sp_o), 32'(v[23:20]));
      chk($sformatf("R3 vec%0d rvalid", i), 32'(rvalid_o), 32'(v[19]));
      if (v[19]) chk($sformatf("R4 vec%0d rdata", i), 32'(rdata_o), 32'(v[18:3]));
      chk($sformatf("R6/R7/R8 vec%0d flags", i), {29'd0, ovf_o, unf_o, clash_o},
          {29'd0, v[2:0]});
    end
    step(1'b0, 1'b0, '0);
    chk("R3 valid pulse ends", 32'(rvalid_o), 0);

    // reset clears sticky flags
    do_reset();
    chk("R1 R8 flags cleared", {29'd0, ovf_o, unf_o, clash_o}, 0);

    // fill to the floor, then overflow
    for (int k = 0; k < CAP; k++) begin
      step(1'b1, 1'b0, DATA_W'(16'h0100 + k));
      chk("R2 fill sp", 32'(sp_o), BASE - 1 - k);
    end
    step(1'b1, 1'b0, 16'hBAD0);
    chk("R5 ovf sp held", 32'(sp_o), FLOOR);
    chk("R5 ovf flag", 32'(ovf_o), 1);
    chk("R9 sp at floor", 32'(sp_o), FLOOR);

    // collision at partly full stack must leave memory untouched
    step(1'b0, 1'b1, '0);
    chk("R4 first pop", 32'(rdata_o), 32'h0100 + CAP - 1);
    step(1'b1, 1'b1, 16'h7777);
    chk("R7 clash flag", 32'(clash_o), 1);
    chk("R7 clash sp", 32'(sp_o), FLOOR + 1);
    chk("R7 clash no valid", 32'(rvalid_o), 0);

    // drain: reverse order, overflow word and clash word never appear
    for (int k = CAP - 2; k >= 0; k--) begin
      step(1'b0, 1'b1, '0);
      chk("R3 drain valid", 32'(rvalid_o), 1);
      chk("R4 R5 drain data", 32'(rdata_o), 32'h0100 + k);
      chk("R8 ovf sticky", 32'(ovf_o), 1);
      step(1'b0, 1'b0, '0);
      chk("R3 single pulse", 32'(rvalid_o), 0);
    end
    chk("R9 sp at base", 32'(sp_o), BASE);
    step(1'b0, 1'b1, '0);
    chk("R6 unf flag", 32'(unf_o), 1);
    chk("R6 unf sp held", 32'(sp_o), BASE);
    chk("R6 unf no valid", 32'(rvalid_o), 0);

    // after errors a valid push/pop still works
    step(1'b1, 1'b0, 16'h5A5A);
    step(1'b0, 1'b1, '0);
    chk("R8 pop after errors", 32'(rdata_o), 32'h5A5A);
    chk("R8 flags kept", {29'd0, ovf_o, unf_o, clash_o}, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule